// File: doc/BRIEF.md
# Count Target and Window Event Unit

This block watches a free-running 32-bit count value and turns two kinds of comparison into interrupt events. The first is a table of exact target values, each of which raises an event when the count lands on it. The second is a table of inclusive windows, each bounded by a low and a high limit, which raise an event when the count enters them. Every entry carries its own task number, which travels with the event so the downstream interrupt controller knows what to run.

All entries are compared against the present count on every cycle. Events that arise together wait in a pending set and leave one per cycle, lowest entry number first, over a valid/ready handshake. A configuration input chooses whether a counter reset freezes event generation until software restarts it, or has no effect on comparison. Software fills both tables through a single word-wide write port.

Top module: `cnt_event_unit`

## Requirements
- R1: After reset no event is offered (`evt_valid_o`=0), all window status bits are 0, every entry is disabled and event generation is running.
- R2: When the count equals the value of an enabled target entry k (0 to NTGT-1), the event appears on the outputs after the next clock edge, with `evt_id_o`=k and `evt_task_o` the entry's task number.
- R3: A target event fires once when the count becomes equal; it does not fire again while the count stays equal, and fires anew after the count leaves and returns.
- R4: A disabled entry never produces an event, whatever its stored limits.
- R5: Window entry r (0 to NRNG-1) reports an event with `evt_id_o`=NTGT+r when the count moves from outside to inside [low, high], both limits included; staying inside or leaving raises nothing.
- R6: `rng_in_o[r]` shows whether the count presented on the previous cycle lay inside enabled window r.
- R7: Pending events leave one per cycle on `evt_valid_o` and `evt_ready_i` both high, lowest entry number first; target entries come before window entries.
- R8: While `evt_valid_o` is high and `evt_ready_i` is low, the offered `evt_id_o` does not change.
- R9: A new event on an entry that is already pending merges with it; only one event is reported for that entry.
- R10: With `cfg_halt_i`=1, a pulse on `cnt_rst_i` stops event generation from the next cycle until `restart_i` is pulsed; matches held across the stop do not fire on restart, since the entry history keeps following the count.
- R11: With `cfg_halt_i`=0, `cnt_rst_i` has no effect on event generation.
- R12: With the default signed comparison, window limits and the count are two's-complement, so 0xFFFFFFFF (-1) lies inside a window from -5 to 5.
- R13: A write with `wr_en_i`=1 updates entry `wr_idx_i` (targets 0..NTGT-1, windows NTGT..NTGT+NRNG-1): field 0 sets the target value or window low limit, field 1 the window high limit, field 2 the task number from bits TASKW-1:0 and the enable from bit 31; field 1 to a target entry and any index beyond the last entry are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CW | Present count value |
| cnt_rst_i | input | 1 | Pulse marking a counter reset |
| cfg_halt_i | input | 1 | 1: a counter reset stops event generation |
| restart_i | input | 1 | Pulse that resumes a stopped event generation |
| wr_en_i | input | 1 | Table write strobe |
| wr_idx_i | input | IDW | Entry number to write |
| wr_fld_i | input | 2 | Field selector: 0 value/low, 1 high, 2 task and enable |
| wr_data_i | input | CW | Write data |
| evt_valid_o | output | 1 | An event is offered |
| evt_ready_i | input | 1 | Consumer takes the offered event |
| evt_id_o | output | IDW | Entry number of the offered event |
| evt_task_o | output | TASKW | Task number of the offered event |
| rng_in_o | output | NRNG | Per-window inside status |

## Verification
A target hit and a window entry can land on the same clock, as can a fresh event on an entry that is still waiting for the consumer. The bench provokes the first by placing a target value inside a window and stepping the count onto it, and the second by holding the consumer off while the count leaves and returns to a target. A behavioural model tracks the pending set, the held offer and the stop state and is compared with the outputs on every cycle, with directed checks on the expected order, the merge and the quiet spell after a halting reset.

// File: rtl/cev_pkg.sv
package cev_pkg;
   typedef enum logic [1:0] {
      FLD_LOW  = 2'd0,
      FLD_HIGH = 2'd1,
      FLD_ATTR = 2'd2,
      FLD_NONE = 2'd3
   } cev_fld_e;
endpackage

// File: rtl/cev_table.sv
module cev_table
   import cev_pkg::*;
#(
   parameter int CW    = 32,
   parameter int TASKW = 8,
   parameter int NTGT  = 48,
   parameter int NRNG  = 8,
   localparam int NTOT = NTGT + NRNG,
   localparam int IDW  = $clog2(NTOT + 1),
   localparam int RW   = $clog2(NRNG)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [IDW-1:0]               wr_idx,
   input  logic [1:0]                   wr_fld,
   input  logic [CW-1:0]                wr_data,
   output logic [NTOT-1:0][CW-1:0]      low_o,
   output logic [NRNG-1:0][CW-1:0]      high_o,
   output logic [NTOT-1:0][TASKW-1:0]   task_o,
   output logic [NTOT-1:0]              en_o
);
   localparam int EN_BIT = CW - 1;

   logic [NTOT-1:0][CW-1:0]    low_q;
   logic [NRNG-1:0][CW-1:0]    high_q;
   logic [NTOT-1:0][TASKW-1:0] task_q;
   logic [NTOT-1:0]            en_q;
   logic [IDW-1:0]             rel_idx;
   logic                       in_table;
   logic                       is_window;

   assign in_table  = wr_idx < IDW'(NTOT);
   assign is_window = wr_idx >= IDW'(NTGT);
   assign rel_idx   = wr_idx - IDW'(NTGT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q  <= '0;
         high_q <= '0;
         task_q <= '0;
         en_q   <= '0;
      end else if (wr_en && in_table) begin
         case (cev_fld_e'(wr_fld))
            FLD_LOW:  low_q[wr_idx] <= wr_data;
            FLD_HIGH: if (is_window) high_q[rel_idx[RW-1:0]] <= wr_data;
            FLD_ATTR: begin
               task_q[wr_idx] <= wr_data[TASKW-1:0];
               en_q[wr_idx]   <= wr_data[EN_BIT];
            end
            default: ;
         endcase
      end
   end

   assign low_o  = low_q;
   assign high_o = high_q;
   assign task_o = task_q;
   assign en_o   = en_q;

   // R13: an out-of-range write leaves every enable untouched
   a_r13_ignore_far: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !in_table) |=> $stable(en_q));
endmodule

// File: rtl/cev_detect.sv
module cev_detect #(
   parameter int CW         = 32,
   parameter int NTGT       = 48,
   parameter int NRNG       = 8,
   parameter bit SIGNED_CMP = 1'b1,
   localparam int NTOT      = NTGT + NRNG
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [CW-1:0]            cnt,
   input  logic                     run,
   input  logic [NTOT-1:0][CW-1:0]  low,
   input  logic [NRNG-1:0][CW-1:0]  high,
   input  logic [NTOT-1:0]          en,
   output logic [NTOT-1:0]          new_evt,
   output logic [NRNG-1:0]          rng_in
);
   logic [NTOT-1:0] hit;
   logic [NTOT-1:0] hit_q;

   for (genvar i = 0; i < NTGT; i++) begin : g_tgt
      assign hit[i] = en[i] && (cnt == low[i]);
   end

   for (genvar r = 0; r < NRNG; r++) begin : g_win
      localparam int E = NTGT + r;
      logic above_lo;
      logic below_hi;
      if (SIGNED_CMP) begin : g_sgn
         assign above_lo = $signed(cnt) >= $signed(low[E]);
         assign below_hi = $signed(cnt) <= $signed(high[r]);
      end else begin : g_uns
         assign above_lo = cnt >= low[E];
         assign below_hi = cnt <= high[r];
      end
      assign hit[E] = en[E] && above_lo && below_hi;

      // R5: entering a window sets its status on the following cycle
      a_r5_entry_status: assert property (@(posedge clk) disable iff (!rst_n)
         new_evt[E] |=> rng_in[r]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_q <= '0;
      else        hit_q <= hit;
   end

   assign new_evt = hit & ~hit_q & {NTOT{run}};
   assign rng_in  = hit_q[NTOT-1:NTGT];

   for (genvar i = 0; i < NTOT; i++) begin : g_once
      // R3: an entry never raises events on two consecutive cycles
      a_r3_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
         new_evt[i] |=> !new_evt[i]);
   end
endmodule

// File: rtl/cev_arbiter.sv
module cev_arbiter #(
   parameter int NTOT = 56,
   localparam int IDW = $clog2(NTOT + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NTOT-1:0] new_evt,
   input  logic            evt_ready,
   output logic            evt_valid,
   output logic [IDW-1:0]  evt_id
);
   logic [NTOT-1:0] pend_q;
   logic [NTOT-1:0] grant;
   logic            hold_q;
   logic [IDW-1:0]  hold_id_q;
   logic [IDW-1:0]  low_id;

   always_comb begin
      low_id = '0;
      for (int i = NTOT - 1; i >= 0; i--) begin
         if (pend_q[i]) low_id = IDW'(i);
      end
   end

   assign evt_valid = |pend_q;
   assign evt_id    = hold_q ? hold_id_q : low_id;

   always_comb begin
      grant = '0;
      if (evt_valid && evt_ready) grant[evt_id] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= '0;
         hold_q    <= 1'b0;
         hold_id_q <= '0;
      end else begin
         pend_q    <= (pend_q & ~grant) | new_evt;
         hold_q    <= evt_valid && !evt_ready;
         hold_id_q <= evt_id;
      end
   end

   // R8: a stalled offer keeps its entry number
   a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_id)));
   // R7: at most one entry leaves per cycle
   a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   // R7: the offered entry is always one that is pending
   a_r7_offer_pending: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> pend_q[evt_id]);
endmodule

// File: rtl/cnt_event_unit.sv
module cnt_event_unit #(
   parameter int CW         = 32,
   parameter int TASKW      = 8,
   parameter int NTGT       = 48,
   parameter int NRNG       = 8,
   parameter bit SIGNED_CMP = 1'b1,
   localparam int IDW       = $clog2(NTGT + NRNG + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CW-1:0]    cnt_i,
   input  logic             cnt_rst_i,
   input  logic             cfg_halt_i,
   input  logic             restart_i,
   input  logic             wr_en_i,
   input  logic [IDW-1:0]   wr_idx_i,
   input  logic [1:0]       wr_fld_i,
   input  logic [CW-1:0]    wr_data_i,
   output logic             evt_valid_o,
   input  logic             evt_ready_i,
   output logic [IDW-1:0]   evt_id_o,
   output logic [TASKW-1:0] evt_task_o,
   output logic [NRNG-1:0]  rng_in_o
);
   localparam int NTOT = NTGT + NRNG;

   if (NTGT < 1 || NRNG < 2) begin : g_bad_depth
      $error("cnt_event_unit: need NTGT >= 1 and NRNG >= 2");
   end
   if (TASKW < 1 || TASKW >= CW) begin : g_bad_task
      $error("cnt_event_unit: TASKW must lie in 1..CW-1");
   end

   logic [NTOT-1:0][CW-1:0]    low_w;
   logic [NRNG-1:0][CW-1:0]    high_w;
   logic [NTOT-1:0][TASKW-1:0] task_w;
   logic [NTOT-1:0]            en_w;
   logic [NTOT-1:0]            new_evt;
   logic                       run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        run_q <= 1'b1;
      else if (cfg_halt_i && cnt_rst_i)  run_q <= 1'b0;
      else if (restart_i)                run_q <= 1'b1;
   end

   cev_table #(.CW(CW), .TASKW(TASKW), .NTGT(NTGT), .NRNG(NRNG)) i_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en_i), .wr_idx(wr_idx_i), .wr_fld(wr_fld_i), .wr_data(wr_data_i),
      .low_o(low_w), .high_o(high_w), .task_o(task_w), .en_o(en_w)
   );

   cev_detect #(.CW(CW), .NTGT(NTGT), .NRNG(NRNG), .SIGNED_CMP(SIGNED_CMP)) i_detect (
      .clk(clk), .rst_n(rst_n), .cnt(cnt_i), .run(run_q),
      .low(low_w), .high(high_w), .en(en_w),
      .new_evt(new_evt), .rng_in(rng_in_o)
   );

   cev_arbiter #(.NTOT(NTOT)) i_arb (
      .clk(clk), .rst_n(rst_n), .new_evt(new_evt), .evt_ready(evt_ready_i),
      .evt_valid(evt_valid_o), .evt_id(evt_id_o)
   );

   assign evt_task_o = task_w[evt_id_o];

   // R10: a stopped unit raises no new events
   a_r10_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> (new_evt == '0));
   // R11: without the halt option a running unit stays running
   a_r11_no_halt: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_halt_i && run_q) |=> run_q);
endmodule

// File: tb/test_cnt_event_unit.sv
module test_cnt_event_unit;
   localparam int CW = 32, TASKW = 8, NTGT = 48, NRNG = 8, NTOT = 56, IDW = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [CW-1:0]    cnt = 32'd50;
   logic             cnt_rst = 1'b0, cfg_halt = 1'b0, restart = 1'b0;
   logic             wr_en = 1'b0;
   logic [IDW-1:0]   wr_idx = '0;
   logic [1:0]       wr_fld = '0;
   logic [CW-1:0]    wr_data = '0;
   logic             evt_ready = 1'b0;
   logic             evt_valid;
   logic [IDW-1:0]   evt_id;
   logic [TASKW-1:0] evt_task;
   logic [NRNG-1:0]  rng_in;

   int nchk = 0, nerr = 0, cycles = 0;

   always #10 clk = ~clk;

   cnt_event_unit i_cnt_event_unit (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cnt_rst_i(cnt_rst),
      .cfg_halt_i(cfg_halt), .restart_i(restart),
      .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_fld_i(wr_fld), .wr_data_i(wr_data),
      .evt_valid_o(evt_valid), .evt_ready_i(evt_ready), .evt_id_o(evt_id),
      .evt_task_o(evt_task), .rng_in_o(rng_in)
   );

   // behavioural reference model
   logic [CW-1:0]    m_low  [NTOT];
   logic [CW-1:0]    m_high [NRNG];
   logic [TASKW-1:0] m_task [NTOT];
   bit               m_en   [NTOT];
   bit               m_seen [NTOT];
   bit               m_pend [NTOT];
   bit               m_hold, m_run;
   int               m_hold_id;

   function automatic int m_offer();
      if (m_hold) return m_hold_id;
      for (int i = 0; i < NTOT; i++) if (m_pend[i]) return i;
      return 0;
   endfunction

   function automatic bit m_any();
      for (int i = 0; i < NTOT; i++) if (m_pend[i]) return 1'b1;
      return 1'b0;
   endfunction

   function automatic bit m_inside(int i);
      if (!m_en[i]) return 1'b0;
      if (i < NTGT) return cnt == m_low[i];
      return ($signed(cnt) >= $signed(m_low[i])) && ($signed(cnt) <= $signed(m_high[i-NTGT]));
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NTOT; i++) begin
            m_low[i] = '0; m_task[i] = '0; m_en[i] = 0; m_seen[i] = 0; m_pend[i] = 0;
         end
         for (int r = 0; r < NRNG; r++) m_high[r] = '0;
         m_hold = 0; m_hold_id = 0; m_run = 1;
      end else begin
         bit now_in [NTOT];
         bit v;
         int id;
         v  = m_any();
         id = m_offer();
         for (int i = 0; i < NTOT; i++) now_in[i] = m_inside(i);
         if (v && evt_ready) m_pend[id] = 0;
         for (int i = 0; i < NTOT; i++)
            if (m_run && now_in[i] && !m_seen[i]) m_pend[i] = 1;
         for (int i = 0; i < NTOT; i++) m_seen[i] = now_in[i];
         m_hold = v && !evt_ready;
         m_hold_id = id;
         if (cfg_halt && cnt_rst) m_run = 0;
         else if (restart) m_run = 1;
         if (wr_en && wr_idx < NTOT) begin
            case (wr_fld)
               2'd0: m_low[wr_idx] = wr_data;
               2'd1: if (wr_idx >= NTGT) m_high[wr_idx-NTGT] = wr_data;
               2'd2: begin m_task[wr_idx] = wr_data[TASKW-1:0]; m_en[wr_idx] = wr_data[31]; end
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         bit mv;
         logic [NRNG-1:0] mr;
         mv = m_any();
         for (int r = 0; r < NRNG; r++) mr[r] = m_seen[NTGT+r];
         chk(evt_valid == mv, "R7 model valid", evt_valid, mv);
         if (mv) begin
            chk(evt_id == m_offer(), "R7 model id", evt_id, m_offer());
            chk(evt_task == m_task[m_offer()], "R13 model task", evt_task, m_task[m_offer()]);
         end
         chk(rng_in == mr, "R6 model window status", rng_in, mr);
      end
   end

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
         end
      end
   end

   task automatic wr(input int idx, input int fld, input logic [CW-1:0] d);
      @(negedge clk);
      wr_en = 1; wr_idx = IDW'(idx); wr_fld = 2'(fld); wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic attr(input int idx, input int tsk, input bit en);
      wr(idx, 2, {en, 23'd0, 8'(tsk)});
   endtask

   task automatic step(input logic [CW-1:0] v);
      @(negedge clk);
      cnt = v;
   endtask

   task automatic expect_evt(input int id, input int tsk, input string tag);
      @(negedge clk);
      chk(evt_valid && evt_id == IDW'(id), tag, evt_id, id);
      chk(evt_task == TASKW'(tsk), tag, evt_task, tsk);
   endtask

   task automatic expect_none(input string tag);
      @(negedge clk);
      chk(!evt_valid, tag, evt_valid, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(!evt_valid, "R1 reset valid", evt_valid, 0);
      chk(rng_in == '0, "R1 reset status", rng_in, 0);

      // R13 table load
      wr(0, 0, 32'd100);  attr(0, 7, 1);
      wr(5, 0, 32'd100);  attr(5, 4, 1);
      wr(3, 0, 32'd200);  attr(3, 9, 1);
      wr(7, 0, 32'd300);  attr(7, 2, 0);
      wr(48, 0, -32'sd5); wr(48, 1, 32'd5); attr(48, 20, 1);
      wr(49, 0, 32'd1000); wr(49, 1, 32'd2000); attr(49, 21, 1);
      expect_none("R4 nothing at rest");

      // R2, R8, R7, R3
      evt_ready = 0;
      step(100);
      expect_evt(0, 7, "R2 target hit");
      repeat (3) expect_evt(0, 7, "R8 held while stalled");
      evt_ready = 1;
      expect_evt(5, 4, "R7 next in order");
      expect_none("R3 no repeat while equal");
      expect_none("R3 still quiet");

      // R4 disabled entry
      step(300);
      expect_none("R4 disabled target");
      expect_none("R4 disabled target later");

      // R12, R5, R6
      step(32'hFFFF_FFFF);
      @(negedge clk);
      chk(evt_valid && evt_id == 48, "R12 signed window entry", evt_id, 48);
      chk(rng_in[0] == 1'b1, "R6 status inside", rng_in[0], 1);
      cnt = 5;
      expect_none("R5 inclusive upper limit no new event");
      step(6);
      @(negedge clk);
      chk(rng_in[0] == 1'b0, "R6 status left", rng_in[0], 0);
      chk(!evt_valid, "R5 leaving is quiet", evt_valid, 0);
      cnt = 5;
      expect_evt(48, 20, "R5 re-entry at limit");

      // R7 simultaneous target and window
      wr(1, 0, 32'd1500); attr(1, 11, 1);
      step(1500);
      expect_evt(1, 11, "R7 target first");
      expect_evt(49, 21, "R7 window second");
      expect_none("R7 drained");

      // R10 halting reset
      cfg_halt = 1;
      @(negedge clk); cnt_rst = 1;
      @(negedge clk); cnt_rst = 0; cnt = 200;
      expect_none("R10 stopped");
      expect_none("R10 stopped later");
      @(negedge clk); restart = 1;
      @(negedge clk); restart = 0;
      expect_none("R10 held match silent on restart");
      step(100);
      expect_evt(0, 7, "R10 resumed");
      expect_evt(5, 4, "R10 resumed second");

      // R11 non-halting reset
      cfg_halt = 0;
      @(negedge clk); cnt_rst = 1;
      @(negedge clk); cnt_rst = 0; cnt = 200;
      expect_evt(3, 9, "R11 reset ignored");
      expect_none("R11 drained");

      // R9 merge
      evt_ready = 0;
      step(100); step(101); step(100);
      @(negedge clk);
      chk(evt_id == 0, "R9 first offer", evt_id, 0);
      evt_ready = 1;
      expect_evt(5, 4, "R9 second offer");
      expect_none("R9 merged, no third");

      // R13 ignored writes
      wr(2, 0, 32'd400); wr(2, 1, 32'd900); attr(2, 6, 1);
      wr(60, 2, {1'b1, 31'd3});
      step(900);
      expect_none("R13 high field on target ignored");
      step(400);
      expect_evt(2, 6, "R13 target value");

      // mixed traffic against the model
      for (int k = 0; k < 600; k++) begin
         logic [CW-1:0] pick [8];
         pick = '{32'd100, 32'd101, 32'd200, 32'hFFFF_FFFF, 32'd5, 32'd1500, 32'd0, 32'd400};
         @(negedge clk);
         cnt = pick[$urandom_range(0, 7)];
         evt_ready = ($urandom_range(0, 3) != 0);
         cnt_rst = ($urandom_range(0, 30) == 0);
         cfg_halt = ($urandom_range(0, 1) == 1);
         restart = ($urandom_range(0, 10) == 0);
      end
      @(negedge clk);
      cnt_rst = 0; restart = 1; evt_ready = 1;
      @(negedge clk); restart = 0;
      repeat (70) @(negedge clk);
      chk(!evt_valid, "R7 all drained", evt_valid, 0);
      finish_run();
   end
endmodule